// File: doc/BRIEF.md
# Byte FIFO to Stream Packet Transmitter

This block drains a byte-granular FIFO and sends its contents as one valid/ready stream packet. The FIFO tells the block how many bytes it holds. The block asks for bytes with a pop request and a pop size that is encoded as the byte count minus one. The oldest bytes sit in the low lanes of the FIFO read word. Each popped word is captured in output registers together with a byte strobe. The next word is popped only in the cycle in which the current beat is accepted.

A control unit starts the block and later raises a no-more-data flag once the FIFO will receive no further bytes. Until that flag is seen, the block cannot know which beat is the last one. For this reason it holds a loaded beat back whenever the FIFO has less than a full bus word behind it. When the flag arrives, the block pops only the bytes that remain, marks the final beat with TLAST and raises a finish flag. A wait flag tells the control unit that the block is starved of data.

The stream side follows the usual valid/ready rules. A beat is transferred on a rising edge where TVALID and TREADY are both high. TREADY may be low for any number of cycles. While TVALID is high it stays high, and TDATA, TSTRB and TLAST hold their values until the beat is accepted. TVALID never depends on TREADY.

Top module: `fifo_stream_tx`

## Requirements
- R1: While reset is held and after it is released, TVALID, TLAST, wait, finish and the pop request are low, and TDATA and TSTRB are zero. The block stays idle until start is pulsed.
- R2: After start, while the FIFO holds fewer than BUS_BYTES bytes and no-more-data is low, the wait flag is high, TVALID is low and nothing is popped.
- R3: Every beat other than the final one carries BUS_BYTES bytes with TSTRB all ones. Bytes leave in FIFO order, and TDATA lane 0 (bits 7:0) carries the oldest byte.
- R4: While TVALID is high and TREADY is low, TVALID, TDATA, TSTRB and TLAST hold their values, and no pop is issued.
- R5: A pop is issued only to load the first beat, or in the cycle where a beat is accepted. The pop size equals the popped byte count minus one and never exceeds the FIFO's used count.
- R6: The final beat carries TLAST and holds the k remaining bytes (1 to BUS_BYTES). Its TSTRB is k low-order ones, and the lanes above k are zero.
- R7: A packet whose length is a multiple of BUS_BYTES ends with a full beat that carries TLAST. No extra beat follows it.
- R8: A packet shorter than BUS_BYTES is sent as a single beat with TLAST.
- R9: If no-more-data arrives while the FIFO is empty and no beat has been sent, the block goes to finish without sending any beat.
- R10: After the final beat is accepted, finish is high and TVALID is low. This holds until a new start, which begins a new packet.
- R11: If the FIFO runs dry in the middle of a packet, TVALID drops and wait rises until data arrives. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse from the control unit that begins a packet |
| no_more_data_i | input | 1 | Control unit: the FIFO will get no further bytes |
| wait_o | output | 1 | Starved: less than one beat available |
| finish_o | output | 1 | Packet fully sent |
| fifo_used_i | input | USED_W | Bytes currently held in the FIFO |
| fifo_pop_req_o | output | 1 | Pop request, taken on the rising edge |
| fifo_pop_size_o | output | SIZE_W | Bytes to pop, minus one |
| fifo_pop_data_i | input | 8*BUS_BYTES | FIFO read word, oldest byte in lane 0 |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 8*BUS_BYTES | Stream data |
| m_tstrb | output | BUS_BYTES | Byte strobes, low-order ones |
| m_tlast | output | 1 | Final beat of the packet |

## Verification
A wrong state in the controller shows at the ports in one of a few ways. A lost or duplicated byte makes the received sequence diverge at the very next accepted beat. A wrong decision at the end of a packet shows as TLAST on the wrong beat, a wrong final strobe, garbage in the unused lanes, or a missing finish within a few cycles of the no-more-data flag. Pops during a stall or beats that change under back-pressure are caught in the cycle they happen. Starvation that is handled wrongly shows as TVALID raised while wait is high.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

  typedef enum logic [3:0] {
    ST_RESET      = 4'd0,
    ST_IDLE       = 4'd1,
    ST_STARVE     = 4'd2,
    ST_FIRST_POP  = 4'd3,
    ST_SEND       = 4'd4,
    ST_DRY        = 4'd5,
    ST_PRE_LAST   = 4'd6,
    ST_LAST_SEND  = 4'd7,
    ST_SHORT_POP  = 4'd8,
    ST_DONE       = 4'd9
  } tx_state_e;

  function automatic int cnt_bits(input int lanes);
    return $clog2(lanes + 1);
  endfunction

endpackage

// File: rtl/fstx_size_conv.sv
module fstx_size_conv #(
  parameter int BUS_BYTES = 4,
  localparam int CNT_W  = fstx_pkg::cnt_bits(BUS_BYTES),
  localparam int SIZE_W = $clog2(BUS_BYTES)
) (
  input  logic [CNT_W-1:0]     count_i,
  output logic [BUS_BYTES-1:0] strobe_o,
  output logic [SIZE_W-1:0]    size_o
);

  // lane i is kept when it lies below the popped byte count
  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign strobe_o[i] = (CNT_W'(i) < count_i);
  end

  // size field is count minus one
  logic [CNT_W-1:0] cnt_m1;
  assign cnt_m1 = count_i - CNT_W'(1);
  assign size_o = cnt_m1[SIZE_W-1:0];

endmodule

// File: rtl/fstx_beat_reg.sv
module fstx_beat_reg #(
  parameter int BUS_BYTES = 4,
  localparam int DATA_W = 8 * BUS_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [BUS_BYTES-1:0] strobe_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [DATA_W-1:0]    tdata_o,
  output logic [BUS_BYTES-1:0] tstrb_o
);

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tdata_o[8*i +: 8] <= 8'h00;
      end else if (load_i) begin
        tdata_o[8*i +: 8] <= strobe_i[i] ? data_i[8*i +: 8] : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tstrb_o <= '0;
    end else if (load_i) begin
      tstrb_o <= strobe_i;
    end
  end

  AST_STRB_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (((tstrb_o + BUS_BYTES'(1)) & tstrb_o) == '0)); // R6

endmodule

// File: rtl/fstx_ctrl.sv
module fstx_ctrl
  import fstx_pkg::*;
#(
  parameter int BUS_BYTES = 4,
  parameter int USED_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              nmd_i,
  input  logic [USED_W-1:0] used_i,
  input  logic              tready_i,
  output logic              tvalid_o,
  output logic              tlast_o,
  output logic              wait_o,
  output logic              finish_o,
  output logic              load_o,
  output logic              use_rem_o
);

  localparam logic [USED_W-1:0] ONE_BEAT  = USED_W'(BUS_BYTES);
  localparam logic [USED_W-1:0] TWO_BEATS = USED_W'(2 * BUS_BYTES);

  tx_state_e st, nxt;
  logic has_one, has_two, has_any;

  assign has_one = (used_i >= ONE_BEAT);
  assign has_two = (used_i >= TWO_BEATS);
  assign has_any = (used_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RESET;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    unique case (st)
      ST_RESET:     nxt = ST_IDLE;
      ST_IDLE:      if (start_i) nxt = ST_STARVE;
      ST_STARVE: begin
        if (has_one)    nxt = ST_FIRST_POP;
        else if (nmd_i) nxt = has_any ? ST_SHORT_POP : ST_DONE;
      end
      ST_FIRST_POP: nxt = has_two ? ST_SEND : ST_DRY;
      ST_SEND:      if (tready_i) nxt = has_two ? ST_SEND : ST_DRY;
      ST_DRY: begin
        if (has_one)    nxt = ST_SEND;
        else if (nmd_i) nxt = has_any ? ST_PRE_LAST : ST_LAST_SEND;
      end
      ST_PRE_LAST:  if (tready_i) nxt = ST_LAST_SEND;
      ST_LAST_SEND: if (tready_i) nxt = ST_DONE;
      ST_SHORT_POP: nxt = ST_LAST_SEND;
      ST_DONE:      if (start_i) nxt = ST_STARVE;
      default:      nxt = ST_RESET;
    endcase
  end

  always_comb begin
    tvalid_o  = 1'b0;
    tlast_o   = 1'b0;
    wait_o    = 1'b0;
    finish_o  = 1'b0;
    load_o    = 1'b0;
    use_rem_o = 1'b0;
    unique case (st)
      ST_STARVE:    wait_o = 1'b1;
      ST_FIRST_POP: load_o = 1'b1;
      ST_SEND: begin
        tvalid_o = 1'b1;
        load_o   = tready_i;
      end
      ST_DRY:       wait_o = 1'b1;
      ST_PRE_LAST: begin
        tvalid_o  = 1'b1;
        load_o    = tready_i;
        use_rem_o = 1'b1;
      end
      ST_LAST_SEND: begin
        tvalid_o = 1'b1;
        tlast_o  = 1'b1;
      end
      ST_SHORT_POP: begin
        load_o    = 1'b1;
        use_rem_o = 1'b1;
      end
      ST_DONE:      finish_o = 1'b1;
      default: ;
    endcase
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid_o && !tready_i) |-> !load_o); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |-> (!tvalid_o && !load_o)); // R10
  AST_WAIT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (!tvalid_o && !load_o)); // R11
  AST_REM_BELOW_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    use_rem_o |-> (has_any && !has_one)); // R6

endmodule

// File: rtl/fifo_stream_tx.sv
module fifo_stream_tx #(
  parameter int BUS_BYTES  = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int DATA_W = 8 * BUS_BYTES,
  localparam int USED_W = $clog2(BUS_BYTES * FIFO_DEPTH) + 1,
  localparam int SIZE_W = $clog2(BUS_BYTES),
  localparam int CNT_W  = fstx_pkg::cnt_bits(BUS_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 no_more_data_i,
  output logic                 wait_o,
  output logic                 finish_o,
  input  logic [USED_W-1:0]    fifo_used_i,
  output logic                 fifo_pop_req_o,
  output logic [SIZE_W-1:0]    fifo_pop_size_o,
  input  logic [DATA_W-1:0]    fifo_pop_data_i,
  output logic                 m_tvalid,
  input  logic                 m_tready,
  output logic [DATA_W-1:0]    m_tdata,
  output logic [BUS_BYTES-1:0] m_tstrb,
  output logic                 m_tlast
);

  logic                 load;
  logic                 use_rem;
  logic [CNT_W-1:0]     pop_count;
  logic [BUS_BYTES-1:0] strobe;

  fstx_ctrl #(
    .BUS_BYTES (BUS_BYTES),
    .USED_W    (USED_W)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .nmd_i     (no_more_data_i),
    .used_i    (fifo_used_i),
    .tready_i  (m_tready),
    .tvalid_o  (m_tvalid),
    .tlast_o   (m_tlast),
    .wait_o    (wait_o),
    .finish_o  (finish_o),
    .load_o    (load),
    .use_rem_o (use_rem)
  );

  // remaining bytes are below one beat whenever use_rem is set
  assign pop_count = use_rem ? fifo_used_i[CNT_W-1:0] : CNT_W'(BUS_BYTES);

  fstx_size_conv #(
    .BUS_BYTES (BUS_BYTES)
  ) i_conv (
    .count_i  (pop_count),
    .strobe_o (strobe),
    .size_o   (fifo_pop_size_o)
  );

  fstx_beat_reg #(
    .BUS_BYTES (BUS_BYTES)
  ) i_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .strobe_i (strobe),
    .data_i   (fifo_pop_data_i),
    .tdata_o  (m_tdata),
    .tstrb_o  (m_tstrb)
  );

  assign fifo_pop_req_o = load;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tstrb) && $stable(m_tlast))); // R4
  AST_POP_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_req_o |-> ({{(USED_W-SIZE_W){1'b0}}, fifo_pop_size_o} < fifo_used_i)); // R5
  AST_POP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop_req_o && m_tvalid) |-> m_tready); // R5
  AST_MID_BEAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> (&m_tstrb)); // R3
  AST_TLAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid); // R6

endmodule

// File: tb/test_fifo_stream_tx.sv
`timescale 1ns/1ps
module test_fifo_stream_tx;

  localparam int W      = 4;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 8 * W;
  localparam int USED_W = $clog2(W * DEPTH) + 1;
  localparam int SIZE_W = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic nmd = 1'b0;
  logic wait_s, finish_s;
  logic [USED_W-1:0] fifo_used = '0;
  logic fifo_pop_req;
  logic [SIZE_W-1:0] fifo_pop_size;
  logic [DATA_W-1:0] fifo_pop_data = '0;
  logic m_tvalid, m_tlast;
  logic m_tready = 1'b0;
  logic [DATA_W-1:0] m_tdata;
  logic [W-1:0] m_tstrb;

  always #2 clk = ~clk;

  fifo_stream_tx #(.BUS_BYTES(W), .FIFO_DEPTH(DEPTH)) i_fifo_stream_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start), .no_more_data_i(nmd),
    .wait_o(wait_s), .finish_o(finish_s),
    .fifo_used_i(fifo_used), .fifo_pop_req_o(fifo_pop_req),
    .fifo_pop_size_o(fifo_pop_size), .fifo_pop_data_i(fifo_pop_data),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tstrb(m_tstrb), .m_tlast(m_tlast)
  );

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 7 + 3) & 255);
  endfunction

  // ---------------- FIFO model and stream monitor (one process) -------------
  logic [7:0] q[$];
  int push_total = 0;
  int pushed = 0;
  int rx_idx = 0, bad_bytes = 0, beats = 0, lasts = 0;
  int nonlast_bad = 0, stall_bad = 0, pop_stall_bad = 0, hi_bad = 0;
  logic [W-1:0] last_strb = '0;
  bit pend_pop = 0;
  int pend_sz = 0;
  bit prev_stall = 0;
  logic [DATA_W-1:0] prev_data = '0;
  logic [W-1:0] prev_strb = '0;
  logic prev_last = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (pend_pop) begin
        for (int k = 0; k < pend_sz; k++) if (q.size() > 0) void'(q.pop_front());
      end
      while (pushed < push_total) begin
        q.push_back(pat(pushed));
        pushed++;
      end
      fifo_used = USED_W'(q.size());
      for (int l = 0; l < W; l++)
        fifo_pop_data[8*l +: 8] = (l < q.size()) ? q[l] : 8'hEE;
      #1;
      pend_pop = rst_n && fifo_pop_req;
      pend_sz  = int'(fifo_pop_size) + 1;
      if (rst_n) begin
        if (prev_stall && (!m_tvalid || m_tdata != prev_data || m_tstrb != prev_strb || m_tlast != prev_last))
          stall_bad++;
        if (m_tvalid && !m_tready && fifo_pop_req) pop_stall_bad++;
        prev_stall = m_tvalid && !m_tready;
        prev_data = m_tdata; prev_strb = m_tstrb; prev_last = m_tlast;
        if (m_tvalid && m_tready) begin
          beats++;
          if (!m_tlast && m_tstrb != {W{1'b1}}) nonlast_bad++;
          for (int l = 0; l < W; l++) begin
            if (m_tstrb[l]) begin
              if (m_tdata[8*l +: 8] != pat(rx_idx)) bad_bytes++;
              rx_idx++;
            end else if (m_tdata[8*l +: 8] != 8'h00) begin
              hi_bad++;
            end
          end
          if (m_tlast) begin
            lasts++;
            last_strb = m_tstrb;
          end
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ready_at(input int mode, input int c);
    case (mode)
      0: return 1;
      1: return c % 2;
      2: return (c % 5) != 0 ? 1 : 0;
      default: return (c >= 20) ? 1 : 0;
    endcase
  endfunction

  task automatic launch();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // feeds n bytes (sent already counted in pre), drains, returns wait seen mid-packet
  task automatic run(input int n, input int pre, input int mode, input int trickle,
                     output bit done, output bit saw_wait);
    int sent = pre;
    done = 0; saw_wait = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      m_tready = 1'(ready_at(mode, c));
      if (sent < n) begin
        if (trickle == 0) begin push_total += n - sent; sent = n; end
        else if (c % 6 == 0) begin push_total += 1; sent++; end
      end else if (pushed == push_total) begin
        nmd = 1'b1;
      end
      if (beats > 0 && wait_s) saw_wait = 1;
      if (finish_s) begin done = 1; break; end
    end
  endtask

  task automatic check_pkt(input int n, input int b0, input int r0, input int l0,
                           input int e0, input string tag);
    int k = n % W;
    logic [W-1:0] exp_strb = (k == 0) ? {W{1'b1}} : W'((1 << k) - 1);
    int exp_beats = (n + W - 1) / W;
    chk(rx_idx - r0 == n, {tag, " R3 byte count"}, rx_idx - r0, n);
    chk(bad_bytes == e0, {tag, " R3 byte order"}, bad_bytes, e0);
    chk(beats - b0 == exp_beats, {tag, " R7 beat count"}, beats - b0, exp_beats);
    if (n > 0) begin
      chk(lasts - l0 == 1, {tag, " R6 one TLAST"}, lasts - l0, 1);
      chk(last_strb == exp_strb, {tag, " R6 final strobe"}, int'(last_strb), int'(exp_strb));
    end
    chk(nonlast_bad == 0, {tag, " R3 full mid beats"}, nonlast_bad, 0);
    chk(hi_bad == 0, {tag, " R6 upper lanes zero"}, hi_bad, 0);
    chk(stall_bad == 0, {tag, " R4 hold under stall"}, stall_bad, 0);
    chk(pop_stall_bad == 0, {tag, " R5 no pop in stall"}, pop_stall_bad, 0);
    chk(finish_s && !m_tvalid, {tag, " R10 finish"}, int'(finish_s), 1);
    nmd = 1'b0; m_tready = 1'b0;
  endtask

  task automatic scenario(input int n, input int mode, input int trickle, input string tag);
    int b0 = beats, r0 = rx_idx, l0 = lasts, e0 = bad_bytes;
    bit done, sw;
    launch();
    run(n, 0, mode, trickle, done, sw);
    chk(done, {tag, " R10 reached finish"}, int'(done), 1);
    check_pkt(n, b0, r0, l0, e0, tag);
    if (trickle != 0) chk(sw, {tag, " R11 wait when dry"}, int'(sw), 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(!m_tvalid && !m_tlast && !wait_s && !finish_s && !fifo_pop_req, "R1 controls low in reset",
        int'(m_tvalid), 0);
    chk(m_tdata == '0 && m_tstrb == '0, "R1 bus cleared", int'(m_tstrb), 0);
    @(negedge clk); rst_n = 1'b1;
    push_total += 8;
    repeat (6) @(negedge clk);
    chk(!m_tvalid && !wait_s && !fifo_pop_req, "R1 idle until start", int'(m_tvalid), 0);
    chk(fifo_used == USED_W'(8), "R1 nothing popped", int'(fifo_used), 8);
  endtask

  task automatic t_idle_packet();
    int b0 = beats, r0 = rx_idx, l0 = lasts, e0 = bad_bytes;
    bit done, sw;
    launch();
    m_tready = 1'b1;
    run(8, 8, 0, 0, done, sw);
    chk(done, "R7 reached finish", int'(done), 1);
    check_pkt(8, b0, r0, l0, e0, "preload8");
    repeat (4) @(negedge clk);
    chk(finish_s && !m_tvalid, "R10 finish holds", int'(finish_s), 1);
  endtask

  task automatic t_starve();
    int b0 = beats, r0 = rx_idx, l0 = lasts, e0 = bad_bytes;
    bit done, sw;
    launch();
    m_tready = 1'b1;
    @(negedge clk); push_total += 3;
    repeat (6) @(negedge clk);
    chk(wait_s == 1'b1, "R2 wait with partial beat", int'(wait_s), 1);
    chk(!m_tvalid && beats == b0, "R2 no beat", beats - b0, 0);
    chk(fifo_used == USED_W'(3), "R2 nothing popped", int'(fifo_used), 3);
    run(11, 3, 0, 0, done, sw);
    chk(done, "R2 reached finish", int'(done), 1);
    check_pkt(11, b0, r0, l0, e0, "starve11");
  endtask

  task automatic t_empty();
    int b0 = beats;
    launch();
    @(negedge clk); nmd = 1'b1;
    repeat (4) @(negedge clk);
    chk(finish_s == 1'b1, "R9 finish on empty", int'(finish_s), 1);
    chk(beats == b0, "R9 no beat sent", beats - b0, 0);
    nmd = 1'b0;
  endtask

  initial begin
    t_reset();
    t_idle_packet();
    scenario(16, 0, 0, "full16");
    scenario(10, 1, 0, "part10");
    scenario(3, 0, 0, "R8 short3");
    scenario(1, 2, 0, "R8 short1");
    scenario(12, 3, 0, "R4 stall12");
    scenario(13, 2, 1, "R11 trickle13");
    scenario(8, 1, 1, "R11 trickle8");
    t_starve();
    t_empty();
    scenario(7, 0, 0, "R10 restart7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

endmodule